// File: doc/BRIEF.md
# Memory-Mapped Character Serial Port Register Block

This block connects a character-oriented serial port to a simple 32-bit CPU load/store bus. Software sees four word registers: receive status, receive data, transmit status and transmit data. Received characters arrive one byte at a time on a valid strobe. Each one is held in a single-character receive buffer until software reads it. Bytes that software writes are offered on a byte-stream output with a valid/ready handshake. The block has no bit-level serialization, no baud generation and no buffering beyond one character in each direction.

Each status register joins a read-only ready flag with a writable interrupt-enable bit. Two level interrupt requests are driven onto fixed lines of an interrupt vector. Line 16 means a received character is waiting. Line 17 means the transmitter can take another byte. The same register window answers at a primary base and at an alias base, so programs written for either address layout run unchanged.

Top module: `mmio_char_port`

## Requirements
- R1: With the default parameters the registers answer at base 0xFFFFC000. Receive status is at byte offset 0x0, receive data at 0x4, transmit status at 0x8 and transmit data at 0xC. A register is selected by address bits [3:2], and bits [1:0] are ignored.
- R2: The same four registers also answer at the alias base 0xFFFF0000, with identical offsets and effects.
- R3: A character on `rx_valid` is stored, and receive status bit 0 reads 1 from the next cycle. A read of receive data returns the byte in bits [7:0] with zeros above, and clears bit 0 at the end of that cycle. If a new character arrives in the same cycle as that read, the read returns the old byte and the new byte is left waiting.
- R4: Receive status bit 1 is a read/write interrupt enable. Interrupt line 16 (`irq_lines[16]`) is 1 exactly while this bit and receive status bit 0 are both 1.
- R5: A character that arrives while bit 0 is still 1, with no read of receive data in that cycle, replaces the waiting byte and sets receive status bit 2 (overrun). Bit 2 stays 1 until software writes a 1 to it.
- R6: A write to transmit data while transmit status bit 0 is 1 presents only bits [7:0] of the written word on `tx_data`, with `tx_valid` high from the next cycle. The byte is held stable until `tx_ready` is seen.
- R7: Transmit status bit 0 reads 1 when no byte is pending. It reads 0 from the cycle after an accepted write until the cycle after the handshake completes. A transmit data write while bit 0 is 0 is dropped.
- R8: Transmit status bit 1 is a read/write interrupt enable. Interrupt line 17 (`irq_lines[17]`) is 1 exactly while this bit and transmit status bit 0 are both 1.
- R9: A read inside the 256-byte window at an offset of 0x10 or above returns zero. A read outside both windows returns zero. A write at any such address changes nothing.
- R10: Writes to read-only bits have no effect. This covers receive status bit 0, transmit status bit 0 and the whole receive data register.
- R11: After reset, receive status reads 0, transmit status reads 1, `tx_valid` is 0 and all interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| rx_valid | input | 1 | Incoming character strobe |
| rx_data | input | 8 | Incoming character |
| tx_valid | output | 1 | Outgoing byte is pending |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Consumer accepts the outgoing byte |
| irq_lines | output | 32 | Interrupt vector: bit 16 is receive-ready, bit 17 is transmit-ready, all other bits are 0 |

## Verification
Every cycle, the bound checker confirms four things:
- an incoming character sets the receive flag;
- a receive-data read clears it unless a new byte arrives in the same cycle;
- overrun stays set until software clears it;
- a pending transmit byte is held stable until the handshake, and an accepted write loads the low byte.

It also ties each interrupt line to its ready condition. The following only show in the bench's scenarios:
- the alias window and unmapped offsets;
- the dropped write while busy and that writes to read-only bits are ignored;
- the same-cycle arrival during a read, and the exact byte sequence seen on the transmit stream.

// File: rtl/mmio_char_port.sv
module mmio_char_port #(
  parameter logic [31:0] BASE_ADDR  = 32'hFFFF_C000,
  parameter logic [31:0] ALIAS_ADDR = 32'hFFFF_0000,
  parameter int          WIN_BITS   = 8,
  parameter int          IRQ_W      = 32,
  parameter int          IRQ_RX_BIT = 16,
  parameter int          IRQ_TX_BIT = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready,
  output logic [IRQ_W-1:0] irq_lines
);
  localparam int IDX_W = WIN_BITS - 2;

  logic [7:0] rx_byte;
  logic       rx_full, rx_ovr, rx_ie, tx_ie;

  wire hit = (bus_addr[31:WIN_BITS] == BASE_ADDR[31:WIN_BITS]) ||
             (bus_addr[31:WIN_BITS] == ALIAS_ADDR[31:WIN_BITS]);
  wire [IDX_W-1:0] idx = bus_addr[WIN_BITS-1:2];

  wire sel_rxs = hit && (idx == IDX_W'(0));
  wire sel_rxd = hit && (idx == IDX_W'(1));
  wire sel_txs = hit && (idx == IDX_W'(2));
  wire sel_txd = hit && (idx == IDX_W'(3));

  wire tx_free = !tx_valid;
  wire rd_rxd  = bus_rd && sel_rxd;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_rxs) bus_rdata = {29'd0, rx_ovr, rx_ie, rx_full};
      if (sel_rxd) bus_rdata = {24'd0, rx_byte};
      if (sel_txs) bus_rdata = {30'd0, tx_ie, tx_free};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_byte <= '0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
      rx_ie   <= 1'b0;
    end else begin
      if (bus_wr && sel_rxs) begin
        rx_ie <= bus_wdata[1];
        if (bus_wdata[2]) rx_ovr <= 1'b0;
      end
      if (rx_valid) begin
        rx_byte <= rx_data;
        rx_full <= 1'b1;
        if (rx_full && !rd_rxd) rx_ovr <= 1'b1;
      end else if (rd_rxd) begin
        rx_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_ie    <= 1'b0;
    end else begin
      if (bus_wr && sel_txs) tx_ie <= bus_wdata[1];
      if (tx_valid && tx_ready) tx_valid <= 1'b0;
      if (bus_wr && sel_txd && tx_free) begin
        tx_data  <= bus_wdata[7:0];
        tx_valid <= 1'b1;
      end
    end
  end

  always_comb begin
    irq_lines             = '0;
    irq_lines[IRQ_RX_BIT] = rx_ie && rx_full;
    irq_lines[IRQ_TX_BIT] = tx_ie && tx_free;
  end

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:8], bus_wdata[0]};
endmodule

module mmio_char_port_chk #(
  parameter logic [31:0] BASE_ADDR  = 32'hFFFF_C000,
  parameter logic [31:0] ALIAS_ADDR = 32'hFFFF_0000,
  parameter int          WIN_BITS   = 8,
  parameter int          IRQ_W      = 32,
  parameter int          IRQ_RX_BIT = 16,
  parameter int          IRQ_TX_BIT = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      bus_addr,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [31:0]      bus_wdata,
  input logic             rx_valid,
  input logic             tx_valid,
  input logic [7:0]       tx_data,
  input logic             tx_ready,
  input logic [IRQ_W-1:0] irq_lines,
  input logic             rx_full,
  input logic             rx_ovr
);
  logic in_win;
  assign in_win = (bus_addr[31:WIN_BITS] == BASE_ADDR[31:WIN_BITS]) ||
                  (bus_addr[31:WIN_BITS] == ALIAS_ADDR[31:WIN_BITS]);
  logic c_rd_rxd, c_wr_rxs, c_wr_txd;
  assign c_rd_rxd = bus_rd && in_win && (bus_addr[WIN_BITS-1:2] == '0 + 1);
  assign c_wr_rxs = bus_wr && in_win && (bus_addr[WIN_BITS-1:2] == '0);
  assign c_wr_txd = bus_wr && in_win && (bus_addr[WIN_BITS-1:2] == '0 + 3);

  p_rx_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_full);
  p_rx_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd_rxd && !rx_valid) |=> !rx_full);
  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr && !(c_wr_rxs && bus_wdata[2])) |=> rx_ovr);
  p_tx_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr_txd && !tx_valid) |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));
  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  p_irq_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lines[IRQ_RX_BIT] |-> rx_full);
  p_irq_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lines[IRQ_TX_BIT] |-> !tx_valid);
endmodule

bind mmio_char_port mmio_char_port_chk #(
  .BASE_ADDR(BASE_ADDR), .ALIAS_ADDR(ALIAS_ADDR), .WIN_BITS(WIN_BITS),
  .IRQ_W(IRQ_W), .IRQ_RX_BIT(IRQ_RX_BIT), .IRQ_TX_BIT(IRQ_TX_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rx_valid(rx_valid),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
  .irq_lines(irq_lines), .rx_full(rx_full), .rx_ovr(rx_ovr)
);

// File: tb/mmio_char_port_bench.sv
module mmio_char_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic [31:0] irq_lines;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  logic [31:0] got;

  always #2.5 clk = ~clk;

  mmio_char_port u_mmio_char_port (.*);

  localparam logic [31:0] B = 32'hFFFF_C000;
  localparam logic [31:0] A = 32'hFFFF_0000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic send_tx(input logic [31:0] a, input logic [31:0] d);
    exp_q.push_back(d[7:0]);
    bus_write(a, d);
  endtask

  task automatic send_rx(input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = c;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  // scoreboard monitor on the transmit stream
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && tx_valid && tx_ready) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R6: unexpected byte %h expected none", tx_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (tx_data !== e) begin
          n_bad++;
          $display("FAIL R6: tx byte got %h expected %h", tx_data, e);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    bus_read(B + 0, got); check("R11 rx status", got, 32'h0);
    bus_read(B + 8, got); check("R11 tx status", got, 32'h1);
    check("R11 irq", irq_lines, 32'h0);
    check("R11 tx_valid", {31'd0, tx_valid}, 32'h0);

    // R8 tx interrupt enable
    bus_write(B + 8, 32'h2);
    #1 check("R8 irq17", irq_lines, 32'h0002_0000);
    bus_read(B + 8, got); check("R8 tx status", got, 32'h3);

    // R6 R7 low byte only, busy flag, drop while busy
    send_tx(B + 12, 32'hA5C3_1F5A);
    #1 check("R6 tx_data", {24'd0, tx_data}, 32'h5A);
    bus_read(B + 8, got); check("R7 busy status", got, 32'h2);
    check("R8 irq17 off while busy", irq_lines, 32'h0);
    bus_write(B + 12, 32'h77);
    #1 check("R7 dropped write", {24'd0, tx_data}, 32'h5A);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_read(B + 8, got); check("R7 free after handshake", got, 32'h3);

    // R2 alias transmit
    send_tx(A + 12, 32'h1234_5642);
    repeat (3) @(negedge clk);
    check("R2 alias tx drained", exp_q.size(), 0);

    // R3 R4 receive
    send_rx(8'h9C);
    bus_read(B + 0, got); check("R3 rx ready", got, 32'h1);
    bus_write(B + 0, 32'h2);
    #1 check("R4 irq16", irq_lines, 32'h0003_0000);
    bus_read(B + 4, got); check("R3 rx data", got, 32'h9C);
    bus_read(B + 0, got); check("R3 ready cleared", got, 32'h2);
    check("R4 irq16 off", irq_lines, 32'h0002_0000);

    // R5 overrun
    send_rx(8'h11);
    send_rx(8'h22);
    bus_read(B + 0, got); check("R5 overrun set", got, 32'h7);
    bus_read(A + 4, got); check("R2 R5 newest byte via alias", got, 32'h22);
    bus_read(B + 0, got); check("R5 overrun sticky", got, 32'h6);
    bus_write(B + 0, 32'h6);
    bus_read(B + 0, got); check("R5 overrun cleared", got, 32'h2);

    // R10 read-only bits
    bus_write(B + 0, 32'h3);
    bus_read(B + 0, got); check("R10 rx ready not writable", got, 32'h2);
    bus_write(B + 4, 32'hFF);
    bus_read(B + 4, got); check("R10 rx data not writable", got, 32'h22);
    bus_read(B + 0, got); check("R10 rx status after data write", got, 32'h2);
    bus_write(B + 8, 32'h0);
    bus_read(B + 8, got); check("R10 tx ready not writable", got, 32'h1);

    // R9 unmapped
    bus_read(B + 16, got); check("R9 offset 0x10", got, 32'h0);
    bus_read(B + 32'h100, got); check("R9 outside window", got, 32'h0);
    bus_read(32'h0000_0004, got); check("R9 low address", got, 32'h0);
    bus_write(32'hFFFF_D00C, 32'h33);
    bus_write(B + 16, 32'h2);
    bus_read(B + 8, got); check("R9 write ignored", got, 32'h1);
    check("R9 no tx", {31'd0, tx_valid}, 32'h0);

    // R1 low address bits ignored
    bus_read(B + 9, got); check("R1 byte offset ignored", got, 32'h1);

    // R3 arrival in the same cycle as read
    send_rx(8'h44);
    @(negedge clk);
    bus_addr = B + 4; bus_rd = 1'b1; rx_valid = 1'b1; rx_data = 8'h55;
    #1 got = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0; rx_valid = 1'b0;
    check("R3 old byte on same-cycle read", got, 32'h44);
    bus_read(B + 0, got); check("R3 new byte waiting no overrun", got, 32'h3);
    bus_read(B + 4, got); check("R3 new byte", got, 32'h55);

    repeat (4) @(negedge clk);
    check("R6 scoreboard empty", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule